// File: doc/BRIEF.md
# Clock-Gated Iterative Multiply/Divide Unit

This block is the multi-cycle integer multiply and divide engine of a 32-bit pipelined core. It runs on its own gated clock. The clock runs only while the instruction in the instruction register calls for a product or a quotient, and while such an operation is still in flight. The rest of the time its registers do not switch, and the last HI/LO result stays in place.

The decode stage presents two instruction fields and a valid strobe. The unit decodes those fields into an enable and a function code. The function code says whether to multiply or divide and whether the operands are signed. When the unit accepts a request, it captures both operands and raises a stop flag that holds instruction fetch. It then performs one shift-add or one restoring shift-subtract step per gated cycle, W steps in all. In the last step it writes the 2W-bit result to the high and low words and drops the flag. The gating cell is a latch that is open while the clock is low, followed by an AND with the clock, so the gated clock carries no partial pulses.

Top module: `md_unit`

## Requirements
- R1: A request is accepted on a rising clock edge when all four of these hold: `ir_valid` is 1, `ir_opc` equals 6'h00, `ir_fn[5:2]` equals 4'b0110, and `stop` is 0. Within the accepted code, `ir_fn[1]`=1 selects divide and `ir_fn[0]`=1 selects unsigned, so the codes are 6'h18 signed multiply, 6'h19 unsigned multiply, 6'h1A signed divide and 6'h1B unsigned divide. Any other field value, and any matching value while `ir_valid` is 0, starts nothing.
- R2: `stop` rises in the cycle after the accepting edge and stays high for exactly W cycles. When it falls, the new result is already on `res_hi`/`res_lo`.
- R3: A multiply writes the full 2W-bit product of the operands, upper half on `res_hi` and lower half on `res_lo`, read as two's complement when signed and as plain binary when unsigned.
- R4: A divide of `opnd_a` by `opnd_b` writes the quotient, truncated toward zero, to `res_lo` and the remainder to `res_hi`. For a signed divide the remainder carries the sign of the dividend, and the most negative value divided by -1 gives a quotient of 0x80000000 with remainder 0.
- R5: A divide by zero, signed or unsigned, gives `res_lo` all ones and `res_hi` equal to `opnd_a`, and takes the normal W cycles.
- R6: A request presented while `stop` is high is ignored. The running operation finishes at its normal time with its own result.
- R7: `gclk_o` has no rising edge in a cycle with no accepted request, no operation running and no reset. Each operation produces exactly W+1 rising edges.
- R8: While idle, `res_hi` and `res_lo` keep their value.
- R9: A synchronous `rst` clears `res_hi`, `res_lo` and `stop`, even in the middle of an operation.
- R10: `gclk_o` is low whenever `clk` is low, and follows `clk` high while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_valid | input | 1 | Instruction register holds an instruction to issue this cycle |
| ir_opc | input | 6 | Major opcode field of the instruction |
| ir_fn | input | 6 | Function field of the instruction |
| opnd_a | input | W | Multiplicand or dividend |
| opnd_b | input | W | Multiplier or divisor |
| res_hi | output | W | Upper product half or remainder |
| res_lo | output | W | Lower product half or quotient |
| stop | output | 1 | Operation in flight; fetch must wait |
| gclk_o | output | 1 | Gated clock that drives the unit's registers |

## Verification
The bench builds the unit with its default parameters: W=32, major opcode 6'h00 and function group 4'b0110. At that width, the 32-cycle stall window and the 33 gated edges per operation are checked at their real length. The full-width corner operands are also reachable: 0x80000000 squared, the all-ones unsigned product, the most negative value divided by -1, and zero divisors with negative dividends. A second request arriving during the stall and a reset arriving mid-operation are both exercised at the same width.

// File: rtl/md_pkg.sv
package md_pkg;

  // Kind of operation captured at the accepting edge.
  typedef struct packed {
    logic is_div;   // 1: divide, 0: multiply
    logic is_uns;   // 1: unsigned operands
  } md_op_t;

endpackage

// File: rtl/md_clk_gate.sv
module md_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);

  logic en_hold;

  // Enable may only change while clk is low; the AND then passes whole pulses.
  always_latch begin
    if (!clk) en_hold <= en;
  end

  assign gclk = clk & en_hold;

endmodule

// File: rtl/md_decode.sv
module md_decode
  import md_pkg::*;
#(
  parameter int              OPC_W   = 6,
  parameter int              FN_W    = 6,
  parameter logic [OPC_W-1:0] OPC_VAL = '0,
  parameter logic [FN_W-3:0]  GRP_VAL = 4'b0110
) (
  input  logic [OPC_W-1:0] ir_opc,
  input  logic [FN_W-1:0]  ir_fn,
  output logic             hit,
  output md_op_t           op
);

  localparam int GRP_LSB = 2;

  logic opc_match;
  logic grp_match;

  assign opc_match = (ir_opc == OPC_VAL);
  assign grp_match = (ir_fn[FN_W-1:GRP_LSB] == GRP_VAL);
  assign hit       = opc_match & grp_match;

  always_comb begin
    op.is_div = ir_fn[1];
    op.is_uns = ir_fn[0];
  end

endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         gclk,
  input  logic         rst,
  input  logic         start,
  input  md_op_t       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam int CW = $clog2(W);
  localparam int DW = 2 * W;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // Magnitude of a value that may be two's complement.
  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  // One shift-add step: adds the multiplicand when the low bit is set, then shifts right.
  function automatic logic [DW-1:0] mul_step(input logic [W-1:0] ph,
                                             input logic [W-1:0] pl,
                                             input logic [W-1:0] m);
    logic [W:0] s;
    s = {1'b0, ph} + (pl[0] ? {1'b0, m} : '0);
    return {s, pl[W-1:1]};
  endfunction

  // One restoring step: shift a dividend bit into the remainder, subtract if it fits.
  function automatic logic [DW-1:0] div_step(input logic [W-1:0] r,
                                             input logic [W-1:0] q,
                                             input logic [W-1:0] d);
    logic [W:0]   sh;
    logic [W+1:0] df;
    sh = {r, q[W-1]};
    df = {1'b0, sh} - {2'b00, d};
    if (!df[W+1]) return {df[W-1:0], q[W-2:0], 1'b1};
    else          return {sh[W-1:0], q[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] neg_w(input logic [W-1:0] x, input logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [DW-1:0] neg_d(input logic [DW-1:0] x, input logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          div_q;
  logic          neg_main_q;
  logic          neg_rem_q;
  logic [W-1:0]  acc_hi_q;
  logic [W-1:0]  acc_lo_q;
  logic [W-1:0]  opm_q;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;

  // Setup values derived from the operands at the accepting edge.
  logic          sa, sb, bz;
  logic [W-1:0]  mag_a, mag_b;
  logic          neg_main_d, neg_rem_d;

  assign sa    = ~op.is_uns & a[W-1];
  assign sb    = ~op.is_uns & b[W-1];
  assign bz    = (b == '0);
  assign mag_a = mag(a, ~op.is_uns);
  assign mag_b = mag(b, ~op.is_uns);

  always_comb begin
    if (op.is_div) begin
      neg_main_d = (sa ^ sb) & ~bz;
      neg_rem_d  = sa;
    end else begin
      neg_main_d = sa ^ sb;
      neg_rem_d  = 1'b0;
    end
  end

  // Iteration and final sign correction.
  logic [DW-1:0] step;
  logic [W-1:0]  step_hi, step_lo;
  logic [DW-1:0] prod_fix;
  logic [W-1:0]  fin_hi, fin_lo;

  assign step    = div_q ? div_step(acc_hi_q, acc_lo_q, opm_q)
                         : mul_step(acc_hi_q, acc_lo_q, opm_q);
  assign step_hi = step[DW-1:W];
  assign step_lo = step[W-1:0];
  assign prod_fix = neg_d(step, neg_main_q);

  always_comb begin
    if (div_q) begin
      fin_hi = neg_w(step_hi, neg_rem_q);
      fin_lo = neg_w(step_lo, neg_main_q);
    end else begin
      fin_hi = prod_fix[DW-1:W];
      fin_lo = prod_fix[W-1:0];
    end
  end

  assign done = busy_q && (cnt_q == LAST);

  always_ff @(posedge gclk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      div_q      <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      acc_hi_q   <= '0;
      acc_lo_q   <= '0;
      opm_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      cnt_q      <= '0;
      div_q      <= op.is_div;
      neg_main_q <= neg_main_d;
      neg_rem_q  <= neg_rem_d;
      acc_hi_q   <= '0;
      acc_lo_q   <= op.is_div ? mag_a : mag_b;
      opm_q      <= op.is_div ? mag_b : mag_a;
    end else if (busy_q) begin
      acc_hi_q <= step_hi;
      acc_lo_q <= step_lo;
      cnt_q    <= cnt_q + 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        hi_q   <= fin_hi;
        lo_q   <= fin_lo;
      end
    end
  end

  assign busy = busy_q;
  assign hi   = hi_q;
  assign lo   = lo_q;

endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int               W       = 32,
  parameter int               OPC_W   = 6,
  parameter int               FN_W    = 6,
  parameter logic [OPC_W-1:0] OPC_VAL = '0,
  parameter logic [FN_W-3:0]  GRP_VAL = 4'b0110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_valid,
  input  logic [OPC_W-1:0] ir_opc,
  input  logic [FN_W-1:0]  ir_fn,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic [W-1:0]     res_hi,
  output logic [W-1:0]     res_lo,
  output logic             stop,
  output logic             gclk_o
);

  // Named internal events, visible to the bound checker.
  logic   dec_hit;
  md_op_t dec_op;
  logic   start_w;
  logic   busy_w;
  logic   done_w;
  logic   gate_en;
  logic   gclk;

  md_decode #(
    .OPC_W  (OPC_W),
    .FN_W   (FN_W),
    .OPC_VAL(OPC_VAL),
    .GRP_VAL(GRP_VAL)
  ) u_dec (
    .ir_opc(ir_opc),
    .ir_fn (ir_fn),
    .hit   (dec_hit),
    .op    (dec_op)
  );

  assign start_w = ir_valid & dec_hit & ~busy_w;
  // Reset must reach the gated flops; busy keeps the clock alive until the last step.
  assign gate_en = rst | start_w | busy_w;

  md_clk_gate u_cg (
    .clk (clk),
    .en  (gate_en),
    .gclk(gclk)
  );

  md_datapath #(
    .W(W)
  ) u_dp (
    .gclk (gclk),
    .rst  (rst),
    .start(start_w),
    .op   (dec_op),
    .a    (opnd_a),
    .b    (opnd_b),
    .busy (busy_w),
    .done (done_w),
    .hi   (res_hi),
    .lo   (res_lo)
  );

  assign stop   = busy_w;
  assign gclk_o = gclk;

endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic         stop,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo
);

  localparam int KW = $clog2(W) + 1;

  logic [KW-1:0] stop_cycles;

  always_ff @(posedge clk) begin
    if (rst)        stop_cycles <= '0;
    else if (start) stop_cycles <= '0;
    else if (stop)  stop_cycles <= stop_cycles + 1'b1;
  end

  // R2
  start_raises_stop_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> stop);

  // R2
  stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !done) |=> stop);

  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !stop);

  // R2
  stall_length_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (stop_cycles == KW'(W - 1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop && !start) |=> ($stable(res_hi) && $stable(res_lo)));

endmodule

bind md_unit md_unit_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start_w),
  .done  (done_w),
  .stop  (stop),
  .res_hi(res_hi),
  .res_lo(res_lo)
);

// File: tb/md_unit_tb.sv
module md_unit_tb;

  localparam int W  = 32;
  localparam int NV = 15;

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  // Function codes: 18 signed mul, 19 unsigned mul, 1A signed div, 1B unsigned div.
  localparam vec_t VT [NV] = '{
    '{6'h19, 32'd7,        32'd6},
    '{6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{6'h18, 32'hFFFFFFFD, 32'd5},
    '{6'h18, 32'h80000000, 32'h80000000},
    '{6'h18, 32'hFFFFFFFF, 32'd1},
    '{6'h19, 32'h12345678, 32'h9ABCDEF0},
    '{6'h1B, 32'd100,      32'd7},
    '{6'h1B, 32'hFFFFFFFF, 32'd10},
    '{6'h1A, 32'hFFFFFF9C, 32'd7},
    '{6'h1A, 32'd100,      32'hFFFFFFF9},
    '{6'h1A, 32'h80000000, 32'hFFFFFFFF},
    '{6'h1B, 32'd5,        32'd0},
    '{6'h1A, 32'hFFFFFF9C, 32'd0},
    '{6'h1B, 32'd3,        32'd9},
    '{6'h1A, 32'd0,        32'hFFFFFFFB}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_valid = 1'b0;
  logic [5:0]  ir_opc = 6'h00;
  logic [5:0]  ir_fn = 6'h00;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] res_hi, res_lo;
  logic        stop;
  logic        gclk_o;

  int n_chk = 0;
  int n_bad = 0;
  int gcnt  = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  always @(posedge gclk_o) gcnt++;

  md_unit u_dut (
    .clk(clk), .rst(rst), .ir_valid(ir_valid), .ir_opc(ir_opc), .ir_fn(ir_fn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_hi(res_hi), .res_lo(res_lo),
    .stop(stop), .gclk_o(gclk_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Independent arithmetic model built on language operators.
  function automatic logic [63:0] model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    longint x, y, p;
    logic [31:0] q, r;
    x = longint'($signed(a));
    y = longint'($signed(b));
    if (!fn[1]) begin
      if (fn[0]) return {32'h0, a} * {32'h0, b};
      p = x * y;
      return p;
    end
    if (b == 32'h0) return {a, 32'hFFFFFFFF};
    if (fn[0]) return {a % b, a / b};
    q = 32'(x / y);
    r = 32'(x % y);
    return {r, q};
  endfunction

  // Issue one operation and check the stall length, gated edges and result.
  task automatic run_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b, input string req);
    int g0;
    int n;
    logic [63:0] exp;
    @(negedge clk);
    ir_valid = 1'b1; ir_opc = 6'h00; ir_fn = fn; opnd_a = a; opnd_b = b;
    g0 = gcnt;
    @(negedge clk);
    check(stop == 1'b1, "R2 stop after accept", {63'h0, stop}, 64'h1);
    ir_valid = 1'b0;
    n = 1;
    while (stop && n < 100) begin
      @(negedge clk);
      if (stop) n++;
    end
    check(n == W, "R2 stall length", 64'(n), 64'(W));
    check(gcnt - g0 == W + 1, "R7 gated edges per op", 64'(gcnt - g0), 64'(W + 1));
    exp = model(fn, a, b);
    check({res_hi, res_lo} == exp, req, {res_hi, res_lo}, exp);
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    int g0;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check({res_hi, res_lo} == 64'h0, "R9 reset result", {res_hi, res_lo}, 64'h0);
    check(stop == 1'b0, "R9 reset stop", {63'h0, stop}, 64'h0);
    // R7 idle: no gated edges
    g0 = gcnt;
    repeat (10) @(negedge clk);
    check(gcnt == g0, "R7 idle gated clock", 64'(gcnt - g0), 64'h0);

    // Vector table: R3 multiply, R4 divide, R5 divide by zero
    for (int i = 0; i < NV; i++) begin
      run_op(VT[i].fn, VT[i].a, VT[i].b,
             VT[i].fn[1] ? ((VT[i].b == 0) ? "R5 div by zero" : "R4 divide") : "R3 multiply");
    end

    // R1 / R8: non-matching words with valid set start nothing and leave results alone
    held = {res_hi, res_lo};
    g0 = gcnt;
    @(negedge clk);
    ir_valid = 1'b1; ir_opc = 6'h00; ir_fn = 6'h1C; opnd_a = 32'd9; opnd_b = 32'd9;
    repeat (3) @(negedge clk);
    ir_opc = 6'h01; ir_fn = 6'h18;
    repeat (3) @(negedge clk);
    ir_valid = 1'b0; ir_opc = 6'h00; ir_fn = 6'h19;   // matching code, valid low
    repeat (4) @(negedge clk);
    check(stop == 1'b0, "R1 no start on other codes", {63'h0, stop}, 64'h0);
    check(gcnt == g0, "R7 no gated edge without request", 64'(gcnt - g0), 64'h0);
    check({res_hi, res_lo} == held, "R8 idle hold", {res_hi, res_lo}, held);

    // R10: gated clock only high with clk during an operation
    @(negedge clk);
    ir_valid = 1'b1; ir_fn = 6'h19; opnd_a = 32'd11; opnd_b = 32'd13;
    @(negedge clk);
    ir_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check(gclk_o == 1'b1, "R10 gated clock high", {63'h0, gclk_o}, 64'h1);
      @(negedge clk); #1;
      check(gclk_o == 1'b0, "R10 gated clock low", {63'h0, gclk_o}, 64'h0);
    end
    while (stop) @(negedge clk);
    check({res_hi, res_lo} == 64'd143, "R3 multiply after gate check", {res_hi, res_lo}, 64'd143);

    // R6: request held during the stall is ignored
    begin
      int n;
      @(negedge clk);
      ir_valid = 1'b1; ir_fn = 6'h19; opnd_a = 32'd1000; opnd_b = 32'd3;
      @(negedge clk);
      ir_fn = 6'h1B; opnd_a = 32'd77; opnd_b = 32'd5;
      n = 1;
      repeat (5) begin @(negedge clk); n++; end
      ir_valid = 1'b0;
      while (stop && n < 100) begin @(negedge clk); if (stop) n++; end
      check(n == W, "R6 stall unchanged by request", 64'(n), 64'(W));
      check({res_hi, res_lo} == 64'd3000, "R6 first result kept", {res_hi, res_lo}, 64'd3000);
    end

    // R9: reset in the middle of an operation
    @(negedge clk);
    ir_valid = 1'b1; ir_fn = 6'h1A; opnd_a = 32'hFFFF0000; opnd_b = 32'd3;
    @(negedge clk);
    ir_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(stop == 1'b0, "R9 mid-op reset stop", {63'h0, stop}, 64'h0);
    check({res_hi, res_lo} == 64'h0, "R9 mid-op reset result", {res_hi, res_lo}, 64'h0);

    // Operation after reset works normally
    run_op(6'h18, 32'hFFFFFFFE, 32'hFFFFFFFD, "R3 multiply after reset");

    finish_run();
  end

endmodule